// File: doc/BRIEF.md
# Two-Channel Burst Pulse Generator

This block drives two independent pulse pins. Each channel owns three 16-bit settings: how many timebase ticks the pin stays high, how many ticks it stays low, and how many high/low periods make up one burst. One tick lasts 100 µs. A prescaler derived from the clock-frequency parameter produces the tick. Settings arrive one at a time as a 16-bit value with an 8-bit select code and a one-cycle write strobe, as a command mailbox front end would deliver them.

A channel runs only while its bit in the enable mask is set. When the bit rises, the channel starts with a high phase. It then emits the programmed number of periods and parks with its pin low. A count of zero makes it run until it is disabled. Clearing the enable bit stops the channel at once. To start a new burst, the host clears the enable bit and sets it again. Settings can be changed only while the channel is disabled.

Top module: `burst_pwm`

## Requirements
- R1: A write with select 8'h10+2n loads the high tick count of channel n, select 8'h11+2n loads its low tick count, and select 8'h14+n loads its pulse count (n = 0 or 1). Any other select changes no setting.
- R2: A high or low tick count written as 0 is stored as 1, so every stored value lies between 1 and 65535.
- R3: A write aimed at a channel whose enable bit is set is ignored. The next burst uses the settings held before that write.
- R4: Each high phase lasts exactly high_ticks × TICK_DIV clock cycles and each low phase exactly low_ticks × TICK_DIV cycles, where TICK_DIV = CLK_HZ/10000 (minimum 2).
- R5: One clock edge after an enable bit is sampled rising, that channel's pin is high and its busy flag is set.
- R6: While an enable bit is clear, that channel's pin and busy flag are low in the same cycle. The channel returns to idle and its phase and pulse counters restart from zero on the next enable.
- R7: With pulse count N > 0, the channel emits exactly N high/low periods. It then holds its pin low and busy clear until the enable bit is cleared.
- R8: With pulse count 0, the channel repeats periods for as long as it is enabled, and busy stays set.
- R9: The two channels share no state. Each runs its own settings at the same time as the other.
- R10: After synchronous reset, both pins and busy flags are low, the tick counts are 1 and the pulse counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe for a setting |
| wr_sel | input | 8 | Select code naming the setting |
| wr_data | input | 16 | Setting value |
| en_mask | input | 2 | Per-channel run enable |
| pwm_out | output | 2 | Pulse pins |
| busy | output | 2 | Set while a channel is inside a burst |

## Verification
The assertions assume that the enable mask is held at a defined level from reset onward. They also assume that the prescale ratio is at least two clocks, so that every high phase spans more than one cycle. The stimulus drives the enable bits to zero before reset is released and changes them only on falling clock edges. It builds the bench with a small clock-frequency value that gives a four-cycle tick. The scoreboard compares each high run, and the low gap before it, against durations that the bench computes from the tick counts it wrote.

// File: rtl/burst_pwm_pkg.sv
package burst_pwm_pkg;

    localparam int NCH   = 2;
    localparam int VAL_W = 16;
    localparam int SEL_W = 8;

    typedef struct packed {
        logic [VAL_W-1:0] hi_ticks;
        logic [VAL_W-1:0] lo_ticks;
        logic [VAL_W-1:0] n_pulses;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_HIGH = 2'd1,
        CH_LOW  = 2'd2,
        CH_DONE = 2'd3
    } ch_state_e;

    function automatic logic [SEL_W-1:0] sel_hi(input int ch);
        return SEL_W'(8'h10 + 2 * ch);
    endfunction

    function automatic logic [SEL_W-1:0] sel_lo(input int ch);
        return SEL_W'(8'h11 + 2 * ch);
    endfunction

    function automatic logic [SEL_W-1:0] sel_cnt(input int ch);
        return SEL_W'(8'h14 + ch);
    endfunction

    function automatic logic [VAL_W-1:0] clamp_div(input logic [VAL_W-1:0] v);
        return (v == '0) ? VAL_W'(1) : v;
    endfunction

endpackage

// File: rtl/bp_tick_gen.sv
module bp_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = !clr && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bp_cfg_regs.sv
module bp_cfg_regs
    import burst_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [VAL_W-1:0] wr_data,
    input  logic [NCH-1:0]   en_mask,
    output chan_cfg_t        cfg [NCH]
);
    for (genvar g = 0; g < NCH; g++) begin : g_reg
        logic wr_ok;
        assign wr_ok = wr_en && !en_mask[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[g].hi_ticks <= VAL_W'(1);
                cfg[g].lo_ticks <= VAL_W'(1);
                cfg[g].n_pulses <= '0;
            end else if (wr_ok) begin
                if (wr_sel == sel_hi(g))  cfg[g].hi_ticks <= clamp_div(wr_data);
                if (wr_sel == sel_lo(g))  cfg[g].lo_ticks <= clamp_div(wr_data);
                if (wr_sel == sel_cnt(g)) cfg[g].n_pulses <= wr_data;
            end
        end
    end
endmodule

// File: rtl/bp_channel.sv
module bp_channel
    import burst_pwm_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  chan_cfg_t cfg,
    output logic      pin,
    output logic      active
);
    ch_state_e        state;
    logic [VAL_W-1:0] ph_cnt;
    logic [VAL_W-1:0] np_cnt;
    logic             running;
    logic             tick;
    logic             last_pulse;

    assign running = (state == CH_HIGH) || (state == CH_LOW);
    assign last_pulse = (cfg.n_pulses != '0) && (np_cnt == cfg.n_pulses - 1'b1);

    bp_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (!running || !en),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state  <= CH_IDLE;
            ph_cnt <= '0;
            np_cnt <= '0;
        end else begin
            case (state)
                CH_IDLE: begin
                    state  <= CH_HIGH;
                    ph_cnt <= '0;
                    np_cnt <= '0;
                end
                CH_HIGH: begin
                    if (tick) begin
                        if (ph_cnt == cfg.hi_ticks - 1'b1) begin
                            state  <= CH_LOW;
                            ph_cnt <= '0;
                        end else begin
                            ph_cnt <= ph_cnt + 1'b1;
                        end
                    end
                end
                CH_LOW: begin
                    if (tick) begin
                        if (ph_cnt == cfg.lo_ticks - 1'b1) begin
                            ph_cnt <= '0;
                            np_cnt <= np_cnt + 1'b1;
                            state  <= last_pulse ? CH_DONE : CH_HIGH;
                        end else begin
                            ph_cnt <= ph_cnt + 1'b1;
                        end
                    end
                end
                default: state <= CH_DONE;
            endcase
        end
    end

    assign pin    = en && (state == CH_HIGH);
    assign active = en && running;
endmodule

// File: rtl/burst_pwm.sv
module burst_pwm
    import burst_pwm_pkg::*;
#(
    parameter int CLK_HZ = 250_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic [1:0]  en_mask,
    output logic [1:0]  pwm_out,
    output logic [1:0]  busy
);
    localparam int RAW_DIV  = CLK_HZ / 10000;
    localparam int TICK_DIV = (RAW_DIV < 2) ? 2 : RAW_DIV;

    chan_cfg_t cfg [NCH];

    bp_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .en_mask (en_mask),
        .cfg     (cfg)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        bp_channel #(.TICK_DIV(TICK_DIV)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .en     (en_mask[g]),
            .cfg    (cfg[g]),
            .pin    (pwm_out[g]),
            .active (busy[g])
        );
    end
endmodule

// File: rtl/burst_pwm_checker.sv
module burst_pwm_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] en_mask,
    input logic [1:0] pwm_out,
    input logic [1:0] busy
);
    for (genvar g = 0; g < 2; g++) begin : g_chk
        // R6: a cleared enable leaves the channel idle after the edge
        a_r6_disable_idles: assert property (@(posedge clk) disable iff (rst)
            !en_mask[g] |=> (!pwm_out[g] && !busy[g]));

        // R5: rising enable starts a high phase on the next edge
        a_r5_start_high: assert property (@(posedge clk) disable iff (rst)
            $rose(en_mask[g]) |=> (pwm_out[g] && busy[g]));

        // R7: a finished burst stays parked while enable holds
        a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
            (en_mask[g] && $past(en_mask[g]) && !busy[g]) |=> (!en_mask[g] || (!busy[g] && !pwm_out[g])));

        // R4: a high phase never lasts a single cycle
        a_r4_high_min: assert property (@(posedge clk) disable iff (rst)
            $rose(pwm_out[g]) |=> (pwm_out[g] || !en_mask[g]));
    end
endmodule

bind burst_pwm burst_pwm_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_mask (en_mask),
    .pwm_out (pwm_out),
    .busy    (busy)
);

// File: tb/tb_burst_pwm.sv
module tb_burst_pwm;
    localparam int TB_CLK_HZ = 40000;
    localparam int TICK      = 4;

    typedef struct {
        int hi;
        int gap;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  en_mask = '0;
    logic [1:0]  pwm_out;
    logic [1:0]  busy;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    exp_t expq [2][$];
    bit   prev [2];
    bit   seen [2];
    int   hi_run [2];
    int   lo_run [2];
    int   cur_gap [2];

    always #2 clk = ~clk;

    burst_pwm #(.CLK_HZ(TB_CLK_HZ)) dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .en_mask (en_mask),
        .pwm_out (pwm_out),
        .busy    (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic wr(input logic [7:0] sel, input logic [15:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input int ch, input int hi_t, input int gap_t);
        exp_t e;
        e.hi  = hi_t * TICK;
        e.gap = gap_t * TICK;
        expq[ch].push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        for (int c = 0; c < 2; c++) begin
            if (rst) begin
                prev[c] = 0; seen[c] = 0; hi_run[c] = 0; lo_run[c] = 0; cur_gap[c] = 0;
            end else begin
                if (pwm_out[c] && !prev[c]) begin
                    cur_gap[c] = seen[c] ? lo_run[c] : 0;
                    hi_run[c] = 1;
                end else if (pwm_out[c]) begin
                    hi_run[c]++;
                end else if (prev[c]) begin
                    seen[c] = 1;
                    lo_run[c] = 1;
                    if (expq[c].size() > 0) begin
                        exp_t e;
                        e = expq[c].pop_front();
                        chk(hi_run[c] == e.hi, "R4 high length", hi_run[c], e.hi);
                        chk(cur_gap[c] == e.gap, "R4 low gap", cur_gap[c], e.gap);
                    end
                end else begin
                    lo_run[c]++;
                end
                if (!en_mask[c]) seen[c] = 0;
                prev[c] = pwm_out[c];
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(pwm_out == 2'b00, "R10 pins after reset", pwm_out, 0);
        chk(busy == 2'b00, "R10 busy after reset", busy, 0);

        // R1 / R7: channel 0 finite burst hi=3 lo=2 count=3
        wr(8'h10, 16'd3);
        wr(8'h11, 16'd2);
        wr(8'h14, 16'd3);
        wr(8'h16, 16'd1);   // R1 unrelated select, must not alter anything
        wr(8'h1F, 16'd9);
        push(0, 3, 0); push(0, 3, 2); push(0, 3, 2);
        @(negedge clk); en_mask[0] = 1'b1;
        @(negedge clk);
        chk(pwm_out[0] == 1'b1, "R5 pin high after enable", pwm_out[0], 1);
        chk(busy[0] == 1'b1, "R5 busy after enable", busy[0], 1);
        idle(65);
        chk(busy[0] == 1'b0, "R7 busy clear after burst", busy[0], 0);
        chk(pwm_out[0] == 1'b0, "R7 pin low after burst", pwm_out[0], 0);
        idle(20);
        chk(busy[0] == 1'b0 && pwm_out[0] == 1'b0, "R7 parked", {busy[0], pwm_out[0]}, 0);
        chk(expq[0].size() == 0, "R7 pulse count", expq[0].size(), 0);
        en_mask[0] = 1'b0;
        idle(2);

        // R2 / R9: both channels at once, ch1 divisors written as zero
        wr(8'h10, 16'd1);
        wr(8'h11, 16'd5);
        wr(8'h14, 16'd2);
        wr(8'h12, 16'd0);
        wr(8'h13, 16'd0);
        wr(8'h15, 16'd2);
        push(0, 1, 0); push(0, 1, 5);
        push(1, 1, 0); push(1, 1, 1);
        @(negedge clk); en_mask = 2'b11;
        idle(20);
        chk(busy == 2'b01, "R9 ch1 done while ch0 runs", busy, 1);
        idle(40);
        chk(busy == 2'b00, "R9 both done", busy, 0);
        chk(expq[1].size() == 0, "R2 ch1 pulses seen", expq[1].size(), 0);
        en_mask = 2'b00;
        idle(2);

        // R8 / R3 / R6: continuous mode on channel 0
        wr(8'h10, 16'd2);
        wr(8'h11, 16'd1);
        wr(8'h14, 16'd0);
        push(0, 2, 0); push(0, 2, 1); push(0, 2, 1); push(0, 2, 1);
        @(negedge clk); en_mask[0] = 1'b1;
        wr(8'h10, 16'd7);   // R3 ignored while enabled
        wr(8'h14, 16'd1);
        idle(47);
        chk(busy[0] == 1'b1, "R8 still running", busy[0], 1);
        chk(pwm_out[0] == 1'b1, "R8 fifth pulse high", pwm_out[0], 1);
        en_mask[0] = 1'b0;
        #1;
        chk(pwm_out[0] == 1'b0, "R6 pin low at once", pwm_out[0], 0);
        chk(busy[0] == 1'b0, "R6 busy low at once", busy[0], 0);
        idle(3);
        // R3: count write was ignored, so the channel still runs continuously
        push(0, 2, 0); push(0, 2, 1);
        @(negedge clk); en_mask[0] = 1'b1;
        idle(40);
        chk(busy[0] == 1'b1, "R3 count write ignored", busy[0], 1);
        chk(expq[0].size() == 0, "R6 restart from zero", expq[0].size(), 0);
        en_mask[0] = 1'b0;
        idle(4);

        chk(expq[0].size() == 0 && expq[1].size() == 0, "R4 queues drained",
            expq[0].size() + expq[1].size(), 0);
        finished = 1;
        finish_run();
    end
endmodule